// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block holds the pending interrupt requests of a processor core and, in each cycle, picks at most one of them to hand to the exception sequencer. Sixteen sources are ranked in a fixed order. Each source has its own gating rule, which depends on the external-enable state, the hypervisor and problem state bits, a resume-from-power-save flag and four hypervisor control bits. The selected source leaves the block both as an index and as a one-hot vector, together with a valid strobe. The choice is combinational from the current pending state and the inputs, so the sequencer sees it in the same cycle.

Edge-type sources are latched into a pending register and cleared when they are delivered. Level-type sources follow their request lines directly, and delivery does not affect them. When the core is waking from a power-save state, the block also supplies a 4-bit wake reason code. It flags whether the delivery should be redirected to the reset vector, and it flags a wake-up in which nothing could be delivered.

Top module: `irq_pick`

## Requirements
- R1: Source index n of `req_i` has priority over every higher index. The indices are: 0 system reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 hypervisor virtualization, 5 external, 6 critical external, 7 watchdog, 8 critical doorbell, 9 fixed-interval timer, 10 programmable-interval timer, 11 decrementer, 12 doorbell, 13 hypervisor doorbell, 14 performance monitor, 15 thermal. `take_id` is the lowest qualifying index, and `take_onehot` has only that bit set.
- R2: Asynchronous delivery is allowed when `ee_i` or `resume_i` is 1. Indices 7 to 15 qualify only when it is allowed.
- R3: Indices 0, 1, 2 and 6 qualify whenever they are pending, with no gating.
- R4: Index 3 qualifies only when `hdice_i` is 1 and either asynchronous delivery is allowed or `hv_i` is 0.
- R5: Index 4 qualifies only when `hvice_i` is 1 and either asynchronous delivery is allowed or `hv_i` is 0.
- R6: Index 5 qualifies when asynchronous delivery is allowed and the condition (`heic_i`=1, `hv_i`=1, `pr_i`=0) does not hold. It also qualifies when `hv_present_i`=1, `hv_i`=0 and `lpes0_i`=0.
- R7: Edge-type indices (0–3, 7–10, 12–15) are set in `pending_o` on the clock edge after their request bit is 1. They are cleared on the edge at which they are delivered, unless the request bit is 1 again in that cycle. `pending_o` is zero after reset.
- R8: Level-type indices 4, 5 and 6 read in `pending_o` as their current request line, and delivery does not change them.
- R9: Index 11 is edge-type when `dec_clr_i` is 1. When `dec_clr_i` is 0 it is level-type, reads as request line 11, and is not cleared.
- R10: When nothing qualifies, `take_valid` is 0, `take_id` is 0, `take_onehot` is 0, and no pending bit is cleared.
- R11: When `resume_i` is 1 and a source is delivered, `wake_code` is 4 for index 0, 8 for index 5, 6 for index 11, 5 for index 12, 3 for index 13 and 9 for index 4. In every other case it is 0.
- R12: `wake_to_reset` is 1 exactly when `resume_i` is 1, a source is delivered, and that source is not index 1 (machine check).
- R13: A cycle with `enter_ps_i`=1 leaves pending bit 3 at 0 after the edge, even if request bit 3 is 1 in that cycle.
- R14: `lost_wake` is 1 exactly when `resume_i` is 1 and nothing is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Request lines, one per source index |
| ee_i | input | 1 | External interrupts enabled |
| hv_i | input | 1 | Hypervisor state |
| pr_i | input | 1 | Problem (user) state |
| resume_i | input | 1 | Core is resuming from power save |
| hdice_i | input | 1 | Hypervisor decrementer enable |
| hvice_i | input | 1 | Hypervisor virtualization enable |
| lpes0_i | input | 1 | External interrupts routed to the guest |
| heic_i | input | 1 | Block externals while in hypervisor state |
| hv_present_i | input | 1 | Hypervisor mode exists |
| dec_clr_i | input | 1 | Decrementer clears on delivery |
| enter_ps_i | input | 1 | Core enters power save this cycle |
| take_valid | output | 1 | A source is delivered this cycle |
| take_id | output | 4 | Index of the delivered source |
| take_onehot | output | 16 | One-hot form of the delivered source |
| pending_o | output | 16 | Effective pending state per index |
| wake_code | output | 4 | Wake reason code |
| wake_to_reset | output | 1 | Redirect this delivery to the reset vector |
| lost_wake | output | 1 | Resume with nothing deliverable |

## Verification
Directed patterns isolate one gate at a time. A lone critical request with external enable off separates the ungated sources from the asynchronous ones. Hypervisor decrementer and external requests are tried under each combination of hypervisor state and control bits, which separates the two routes to delivery. Paired edge and level requests show the difference between clear-on-delivery and held state, and the decrementer is run under both clear settings. Sparse random requests with random control bits then pit many sources against each other, so a priority or gating slip changes the selected index.

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 16,
  parameter int IDW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            ee_i,
  input  logic            hv_i,
  input  logic            pr_i,
  input  logic            resume_i,
  input  logic            hdice_i,
  input  logic            hvice_i,
  input  logic            lpes0_i,
  input  logic            heic_i,
  input  logic            hv_present_i,
  input  logic            dec_clr_i,
  input  logic            enter_ps_i,
  output logic            take_valid,
  output logic [IDW-1:0]  take_id,
  output logic [NSRC-1:0] take_onehot,
  output logic [NSRC-1:0] pending_o,
  output logic [3:0]      wake_code,
  output logic            wake_to_reset,
  output logic            lost_wake
);
  localparam int I_MCK = 1, I_HDEC = 3, I_HVIRT = 4, I_EXT = 5, I_CEXT = 6;
  localparam int I_FIRST_ASYNC = 7, I_DEC = 11, I_DB = 12, I_HDB = 13;

  logic [NSRC-1:0] pend_q, pend_d, level_m, eff, ok, cand, clr;
  logic            async_ok;

  assign async_ok = ee_i | resume_i;

  always_comb begin
    level_m = '0;
    level_m[I_HVIRT] = 1'b1;
    level_m[I_EXT]   = 1'b1;
    level_m[I_CEXT]  = 1'b1;
    level_m[I_DEC]   = ~dec_clr_i;
  end

  assign eff       = (pend_q & ~level_m) | (req_i & level_m);
  assign pending_o = eff;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_gate
      if (g == I_HDEC) begin : g_hdec
        assign ok[g] = hdice_i & (async_ok | ~hv_i);
      end else if (g == I_HVIRT) begin : g_hvirt
        assign ok[g] = hvice_i & (async_ok | ~hv_i);
      end else if (g == I_EXT) begin : g_ext
        assign ok[g] = (async_ok & ~(heic_i & hv_i & ~pr_i)) |
                       (hv_present_i & ~hv_i & ~lpes0_i);
      end else if (g >= I_FIRST_ASYNC) begin : g_async
        assign ok[g] = async_ok;
      end else begin : g_free
        assign ok[g] = 1'b1;
      end
    end
  endgenerate

  assign cand = eff & ok;

  always_comb begin
    take_onehot = '0;
    take_id     = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        take_onehot = '0;
        take_onehot[i] = 1'b1;
        take_id = IDW'(i);
      end
    end
  end

  assign take_valid = |cand;
  assign clr        = take_onehot & ~level_m;

  always_comb begin
    pend_d = (pend_q & ~clr) | req_i;
    if (enter_ps_i) pend_d[I_HDEC] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_comb begin
    wake_code = 4'h0;
    if (resume_i && take_valid) begin
      case (take_id)
        IDW'(0):       wake_code = 4'h4;
        IDW'(I_EXT):   wake_code = 4'h8;
        IDW'(I_DEC):   wake_code = 4'h6;
        IDW'(I_DB):    wake_code = 4'h5;
        IDW'(I_HDB):   wake_code = 4'h3;
        IDW'(I_HVIRT): wake_code = 4'h9;
        default:       wake_code = 4'h0;
      endcase
    end
  end

  assign wake_to_reset = resume_i & take_valid & (take_id != IDW'(I_MCK));
  assign lost_wake     = resume_i & ~take_valid;
endmodule

// File: rtl/irq_pick_chk.sv
module irq_pick_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] req_i,
  input logic        ee_i,
  input logic        resume_i,
  input logic        enter_ps_i,
  input logic        take_valid,
  input logic [3:0]  take_id,
  input logic [15:0] take_onehot,
  input logic [15:0] pending_o,
  input logic        wake_to_reset,
  input logic        lost_wake
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_onehot));
  p_async_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_id >= 4'd7) |-> (ee_i || resume_i));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_id == 4'd0 && !req_i[0] && !enter_ps_i) |=> !pending_o[0]);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid |-> (take_onehot == 16'h0));
  p_redirect_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wake_to_reset |-> (resume_i && take_id != 4'd1));
  p_hdec_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ps_i |=> !pending_o[3]);
  p_lost_r14: assert property (@(posedge clk) disable iff (!rst_n)
    lost_wake |-> (resume_i && !take_valid));
endmodule

bind irq_pick irq_pick_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .ee_i(ee_i), .resume_i(resume_i),
  .enter_ps_i(enter_ps_i), .take_valid(take_valid), .take_id(take_id),
  .take_onehot(take_onehot), .pending_o(pending_o),
  .wake_to_reset(wake_to_reset), .lost_wake(lost_wake)
);

// File: tb/tb_irq_pick.sv
module tb_irq_pick;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [15:0] req = '0;
  logic ee = 0, hv = 0, pr = 0, rs = 0, hdice = 0, hvice = 0, lpes0 = 0;
  logic heic = 0, hvp = 0, dclr = 0, eps = 0;
  logic        take_valid, wake_to_reset, lost_wake;
  logic [3:0]  take_id, wake_code;
  logic [15:0] take_onehot, pending_o;

  int errors = 0, checks = 0;
  logic [15:0] pm = '0;
  string tag = "R10";
  bit done = 0;

  irq_pick dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ee_i(ee), .hv_i(hv), .pr_i(pr),
    .resume_i(rs), .hdice_i(hdice), .hvice_i(hvice), .lpes0_i(lpes0),
    .heic_i(heic), .hv_present_i(hvp), .dec_clr_i(dclr), .enter_ps_i(eps),
    .take_valid(take_valid), .take_id(take_id), .take_onehot(take_onehot),
    .pending_o(pending_o), .wake_code(wake_code),
    .wake_to_reset(wake_to_reset), .lost_wake(lost_wake)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] lvl_mask();
    logic [15:0] m = 16'h0070;
    m[11] = ~dclr;
    return m;
  endfunction

  function automatic logic [15:0] m_eff();
    return (pm & ~lvl_mask()) | (req & lvl_mask());
  endfunction

  function automatic logic [15:0] m_ok();
    logic a = ee | rs;
    logic [15:0] k = '0;
    k[0] = 1; k[1] = 1; k[2] = 1; k[6] = 1;
    k[3] = hdice & (a | ~hv);
    k[4] = hvice & (a | ~hv);
    k[5] = (a & ~(heic & hv & ~pr)) | (hvp & ~hv & ~lpes0);
    for (int i = 7; i < 16; i++) k[i] = a;
    return k;
  endfunction

  function automatic int m_pick();
    logic [15:0] c = m_eff() & m_ok();
    for (int i = 0; i < 16; i++) if (c[i]) return i;
    return -1;
  endfunction

  function automatic logic [3:0] m_code(int p);
    if (!rs || p < 0) return 4'h0;
    case (p)
      0: return 4'h4;  5: return 4'h8;  11: return 4'h6;
      12: return 4'h5; 13: return 4'h3; 4: return 4'h9;
      default: return 4'h0;
    endcase
  endfunction

  task automatic chk(string t, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic step();
    int p;
    logic [15:0] oh;
    #1;
    p  = m_pick();
    oh = (p < 0) ? 16'h0 : (16'h1 << p);
    chk({tag, " valid"}, {15'h0, take_valid}, {15'h0, p >= 0});
    chk({tag, " id"}, {12'h0, take_id}, (p < 0) ? 16'h0 : 16'(p));
    chk({tag, " onehot"}, take_onehot, oh);
    chk({tag, " pending R7"}, pending_o, m_eff());
    chk("R11 wake_code", {12'h0, wake_code}, {12'h0, m_code(p)});
    chk("R12 wake_to_reset", {15'h0, wake_to_reset}, {15'h0, rs && p >= 0 && p != 1});
    chk("R14 lost_wake", {15'h0, lost_wake}, {15'h0, rs && p < 0});
    @(posedge clk);
    pm = (pm & ~(oh & ~lvl_mask())) | req;
    if (eps) pm[3] = 1'b0;
    @(negedge clk);
  endtask

  task automatic ctl(logic e, logic h, logic p_, logic r);
    ee = e; hv = h; pr = p_; rs = r;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R10 reset"; step();
    tag = "R3";  req = 16'h0040; step();
    tag = "R8";  step(); req = '0;
    tag = "R2";  req = 16'h0080; step(); req = '0; step();
    ee = 1; step(); ee = 0;
    tag = "R4";  req = 16'h0008; step(); req = '0; hv = 1; step();
    hdice = 1; step(); hv = 0; step();
    tag = "R13"; req = 16'h0008; hdice = 0; step(); eps = 1; step(); eps = 0; step();
    tag = "R5";  req = 16'h0010; hvice = 1; hv = 1; step(); hv = 0; step(); step(); hvice = 0; req = '0;
    tag = "R6";  req = 16'h0020; ctl(1, 1, 0, 0); heic = 1; step();
    pr = 1; step(); ctl(0, 0, 0, 0); hvp = 1; step(); lpes0 = 1; step();
    heic = 0; lpes0 = 0; hvp = 0; req = '0;
    tag = "R9";  dclr = 1; req = 16'h0800; step(); req = '0; ee = 1; step(); step();
    dclr = 0; req = 16'h0800; step(); step(); req = '0; step(); ee = 0;
    tag = "R11"; rs = 1; req = 16'h0001; step(); req = '0; step();
    req = 16'h3000; step(); step(); req = '0; step();
    tag = "R12"; req = 16'h0002; step(); req = '0; step(); rs = 0;
    tag = "R1";
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] r = '0;
      for (int b = 0; b < 16; b++) r[b] = ($urandom % 10) == 0;
      req = r;
      ee = $urandom; hv = $urandom; pr = $urandom; rs = ($urandom % 4) == 0;
      hdice = $urandom; hvice = $urandom; lpes0 = $urandom; heic = $urandom;
      hvp = $urandom; dclr = $urandom; eps = ($urandom % 8) == 0;
      step();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial void'($urandom(32'd4711));
endmodule